// File: doc/BRIEF.md
# Byte ALU with Dedicated Status Flags

This block is a single-cycle-latency arithmetic and logic unit for byte-wide unsigned operands. The caller places two operands and a 5-bit operation code on the inputs and raises a valid strobe for one cycle. The unit registers the operation's outputs at that clock edge. On the next cycle it presents a result byte, a 5-bit flag vector, an error bit and a done pulse.

Each condition the unit can report has a bit of its own in the flag vector: carry, borrow, equal, less-than and greater-than. A flag that the current operation does not produce reads as zero. Shift and rotate amounts come from the low three bits of the second operand. An operation code outside the defined set produces an error pulse instead of a result.

Sequencing is done by a two-state machine:
- **IDLE**: nothing to present. It moves to **SHOW** on a cycle with the strobe high (transition *accept*) and otherwise stays in IDLE (transition *wait*).
- **SHOW**: the done pulse is driven. It stays in SHOW when another strobe arrives (transition *chain*) and returns to IDLE when none arrives (transition *drain*).

Result and flags hold their value until the next accepted operation.

Top module: `alu8_flags`

## Requirements
- R1: Code 5'b00001 adds the operands as unsigned values: the result is the low 8 bits of the 9-bit sum, and flags[4] (carry) is the sum's ninth bit.
- R2: Code 5'b00010 computes a minus b as a 9-bit value: the result is its low 8 bits, and flags[3] (borrow) is set exactly when a is less than b.
- R3: Codes 5'b00011, 5'b00100 and 5'b00101 give the bitwise AND, OR and XOR of the operands.
- R4: Code 5'b00110 gives the inverse of a. The value of b has no effect on the result.
- R5: Codes 5'b00111 (left) and 5'b01000 (right) shift a by b[2:0] places with zero fill. b[7:3] has no effect.
- R6: Codes 5'b01001 (left) and 5'b01010 (right) rotate a by b[2:0] places. A bit leaving one end enters at the other. b[7:3] has no effect.
- R7: Codes 5'b01011, 5'b01100 and 5'b01101 set flags[2] when a equals b, flags[1] when a is below b, and flags[0] when a is above b, all unsigned. The result reads zero for these codes.
- R8: Every flag bit that the operation does not produce is zero, so at most one flag is ever set.
- R9: Code 5'b00000 and codes 5'b01110 to 5'b11111 raise the error output together with done. Result and flags read zero for them.
- R10: The outputs of an operation appear, with a one-cycle done pulse, in the cycle after the edge that sampled the strobe. Error is high only together with done. Result and flags hold their value while no strobe arrives.
- R11: A synchronous active-low reset clears the result, flags, error and done.
- R12: Strobes on consecutive cycles each give their own done cycle (state SHOW kept through *chain*). The first idle cycle after them drops done (*drain*).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Launches an operation on this edge |
| op_code | input | 5 | Operation selector |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand; bits [2:0] give the shift/rotate amount |
| res_out | output | 8 | Registered result |
| flags_out | output | 5 | Carry [4], borrow [3], equal [2], less [1], greater [0] |
| op_done | output | 1 | One-cycle pulse per accepted operation |
| op_err | output | 1 | Invalid operation code, pulses with done |

## Verification
The assertions assume that op_valid is a known 0 or 1 at every sampled edge after reset. They also assume that reset is held for at least one edge before the first operation, because the timing and hold properties look back one cycle. The stimulus drives every input only on falling edges, holds op_valid low during reset, and sweeps all 32 code values. That sweep includes the unused ones and covers operands whose upper shift bits are set. Strobes are sent in bursts with gaps of random length, so both the chain and the drain transitions occur. One reset is applied in the middle of the run.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OPC_W  = 5;
    localparam int FLAG_W = 5;

    localparam int FL_CARRY  = 4;
    localparam int FL_BORROW = 3;
    localparam int FL_EQ     = 2;
    localparam int FL_LT     = 1;
    localparam int FL_GT     = 0;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOT,
        K_SHL, K_SHR, K_ROL, K_ROR,
        K_CEQ, K_CLT, K_CGT, K_BAD
    } kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } st_e;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output kind_e            kind
);

    always_comb begin
        unique case (opc)
            5'd1:    kind = K_ADD;
            5'd2:    kind = K_SUB;
            5'd3:    kind = K_AND;
            5'd4:    kind = K_OR;
            5'd5:    kind = K_XOR;
            5'd6:    kind = K_NOT;
            5'd7:    kind = K_SHL;
            5'd8:    kind = K_SHR;
            5'd9:    kind = K_ROL;
            5'd10:   kind = K_ROR;
            5'd11:   kind = K_CEQ;
            5'd12:   kind = K_CLT;
            5'd13:   kind = K_CGT;
            default: kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
    parameter  int W  = 8,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          go_left,
    input  logic          wrap,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stg [0:SW];

    assign stg[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int K = 1 << s;
        logic [W-1:0] moved;

        always_comb begin
            if (go_left) begin
                moved = {stg[s][W-K-1:0], (wrap ? stg[s][W-1:W-K] : {K{1'b0}})};
            end else begin
                moved = {(wrap ? stg[s][K-1:0] : {K{1'b0}}), stg[s][W-1:K]};
            end
        end

        assign stg[s+1] = amt[s] ? moved : stg[s];
    end

    assign dout = stg[SW];

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  kind_e             kind,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [W-1:0]      shifted,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] flags,
    output logic              bad
);

    logic [W:0] sum;
    logic [W:0] diff;

    assign sum  = {1'b0, a} + {1'b0, b};
    assign diff = {1'b0, a} - {1'b0, b};

    always_comb begin
        res   = '0;
        flags = '0;
        bad   = 1'b0;
        unique case (kind)
            K_ADD: begin
                res             = sum[W-1:0];
                flags[FL_CARRY] = sum[W];
            end
            K_SUB: begin
                res              = diff[W-1:0];
                flags[FL_BORROW] = diff[W];
            end
            K_AND: res = a & b;
            K_OR:  res = a | b;
            K_XOR: res = a ^ b;
            K_NOT: res = ~a;
            K_SHL, K_SHR, K_ROL, K_ROR: res = shifted;
            K_CEQ: flags[FL_EQ] = (a == b);
            K_CLT: flags[FL_LT] = (a < b);
            K_CGT: flags[FL_GT] = (a > b);
            K_BAD: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int SHW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] res_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic              op_done,
    output logic              op_err
);

    kind_e             kind;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] res_d;
    logic [FLAG_W-1:0] flags_d;
    logic              bad_d;
    logic              go_left;
    logic              wrap;
    st_e               st_q;
    st_e               st_d;

    alu8_decode u_decode (
        .opc  (op_code),
        .kind (kind)
    );

    assign go_left = (kind == K_SHL) || (kind == K_ROL);
    assign wrap    = (kind == K_ROL) || (kind == K_ROR);

    alu8_shifter #(.W(DATA_W)) u_shift (
        .din     (opnd_a),
        .amt     (opnd_b[SHW-1:0]),
        .go_left (go_left),
        .wrap    (wrap),
        .dout    (shifted)
    );

    alu8_arith #(.W(DATA_W)) u_arith (
        .kind    (kind),
        .a       (opnd_a),
        .b       (opnd_b),
        .shifted (shifted),
        .res     (res_d),
        .flags   (flags_d),
        .bad     (bad_d)
    );

    // Next-state logic: accept / wait from IDLE, chain / drain from SHOW
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = op_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: st_d = op_valid ? ST_SHOW : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out   <= '0;
            flags_out <= '0;
            op_err    <= 1'b0;
        end else begin
            op_err <= op_valid & bad_d;
            if (op_valid) begin
                res_out   <= res_d;
                flags_out <= flags_d;
            end
        end
    end

    assign op_done = (st_q == ST_SHOW);

    // R10 / R12: done follows each strobe by one cycle
    a_r10_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> op_done);
    a_r12_drain_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !op_done);
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> op_done);
    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(res_out) && $stable(flags_out)));
    // R8: a single flag at most
    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags_out) <= 1);
    // R7: compare codes leave the result at zero
    a_r7_cmp_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code inside {5'd11, 5'd12, 5'd13})) |=> (res_out == '0));
    // R9: unused codes report an error and zero outputs
    a_r9_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !(op_code inside {[5'd1:5'd13]})) |=>
            (op_err && res_out == '0 && flags_out == '0));
    // R11: reset clears every output
    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!op_done && !op_err && res_out == '0 && flags_out == '0));

endmodule

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic [7:0] res_out;
    logic [4:0] flags_out;
    logic       op_done;
    logic       op_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu8_flags dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .res_out   (res_out),
        .flags_out (flags_out),
        .op_done   (op_done),
        .op_err    (op_err)
    );

    // Reference: {err, flags[4:0], result[7:0]}
    function automatic logic [13:0] model(input logic [4:0] c, input logic [7:0] a, input logic [7:0] b);
        int          x;
        int          n;
        logic [7:0]  r;
        logic [4:0]  f;
        logic        e;
        r = 0; f = 0; e = 0;
        n = b % 8;
        case (c)
            1:  begin x = a + b; r = x[7:0]; f[4] = (x > 255); end
            2:  begin x = a - b; r = x[7:0]; f[3] = (a < b); end
            3:  r = a & b;
            4:  r = a | b;
            5:  r = a ^ b;
            6:  r = 8'hFF - a;
            7:  begin x = a * (1 << n); r = x[7:0]; end
            8:  r = 8'(a / (1 << n));
            9:  begin r = a; for (int i = 0; i < n; i++) r = {r[6:0], r[7]}; end
            10: begin r = a; for (int i = 0; i < n; i++) r = {r[0], r[7:1]}; end
            11: f[2] = (a == b);
            12: f[1] = (a < b);
            13: f[0] = (a > b);
            default: e = 1;
        endcase
        return {e, f, r};
    endfunction

    function automatic string tag_of(input logic [4:0] c);
        case (c)
            1: return "R1";
            2: return "R2";
            3, 4, 5: return "R3";
            6: return "R4";
            7, 8: return "R5";
            9, 10: return "R6";
            11, 12, 13: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [13:0] q[$];
    string       tq[$];
    logic [12:0] held = '0;
    bit          rst_seen = 1'b0;
    bit          prev_v = 1'b0;
    bit          chain = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); tq.delete();
            held = '0;
            rst_seen = 1'b1;
            prev_v = 1'b0;
        end else begin
            rst_seen = 1'b0;
            chain = prev_v && op_valid;
            if (op_valid) begin
                q.push_back(model(op_code, opnd_a, opnd_b));
                tq.push_back(tag_of(op_code));
            end
            prev_v = op_valid;
        end
    end

    always @(negedge clk) begin
        if (rst_seen) begin
            chk(op_done == 0, "R11", "done", op_done, 0);
            chk(op_err == 0, "R11", "err", op_err, 0);
            chk(res_out == 0, "R11", "result", res_out, 0);
            chk(flags_out == 0, "R11", "flags", flags_out, 0);
        end else if (q.size() > 0) begin
            logic [13:0] e;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            chk(op_done == 1, chain ? "R12" : "R10", "done", op_done, 1);
            chk(res_out == e[7:0], t, "result", res_out, e[7:0]);
            chk(flags_out == e[12:8], (e[12:8] == 0 && flags_out != 0) ? "R8" : t, "flags", flags_out, e[12:8]);
            chk(op_err == e[13], t, "err", op_err, e[13]);
            held = e[12:0];
        end else begin
            chk(op_done == 0, "R12", "done idle", op_done, 0);
            chk(op_err == 0, "R10", "err idle", op_err, 0);
            chk(res_out == held[7:0], "R10", "result hold", res_out, held[7:0]);
            chk(flags_out == held[12:8], "R10", "flags hold", flags_out, held[12:8]);
        end
    end

    task automatic issue(input logic [4:0] c, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; opnd_a = a; opnd_b = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            op_code = 5'($urandom);
            opnd_a = 8'($urandom);
            opnd_b = 8'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        issue(1, 8'd200, 8'd100);          // R1 carry
        issue(1, 8'd255, 8'd1);            // R1 wrap to zero
        issue(1, 8'd0, 8'd0);
        idle(1);
        issue(2, 8'd5, 8'd7);              // R2 borrow
        issue(2, 8'd7, 8'd5);
        issue(2, 8'd0, 8'd0);
        issue(3, 8'hF0, 8'h3C);            // R3
        issue(4, 8'hF0, 8'h3C);
        issue(5, 8'hF0, 8'h3C);
        issue(6, 8'h5A, 8'hFF);            // R4 b ignored
        issue(6, 8'h5A, 8'h00);
        issue(7, 8'h81, 8'hF9);            // R5 amount 1, upper b set
        issue(8, 8'h81, 8'h07);
        issue(7, 8'h81, 8'h08);            // R5 amount 0
        issue(9, 8'h81, 8'h01);            // R6
        issue(10, 8'h81, 8'hFB);
        issue(9, 8'hA5, 8'hF8);
        idle(2);
        issue(11, 8'h33, 8'h33);           // R7
        issue(11, 8'h33, 8'h34);
        issue(12, 8'd3, 8'd4);
        issue(12, 8'd4, 8'd3);
        issue(13, 8'd4, 8'd3);
        issue(13, 8'd9, 8'd9);
        issue(0, 8'hFF, 8'hFF);            // R9
        issue(14, 8'h12, 8'h34);
        issue(31, 8'hAA, 8'h55);
        idle(3);
        for (int i = 0; i < 32; i++) issue(5'(i), 8'($urandom), 8'($urandom));
        idle(1);
        for (int i = 0; i < 400; i++) begin
            issue(5'($urandom), 8'($urandom), 8'($urandom));
            if ($urandom % 3 == 0) idle(1 + $urandom % 3);
        end
        issue(1, 8'd9, 8'd9);
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;                      // R11 mid-run reset
        idle(2);
        rst_n = 1'b1;
        idle(1);
        for (int i = 0; i < 200; i++) issue(5'($urandom % 16), 8'($urandom), 8'($urandom));
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule